// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands. Each operand has a sign bit, an 8-bit exponent stored with a bias of 127, and a 23-bit fraction with an implied leading one. The block forms the result sign, adds the exponents and removes one bias, multiplies the two 24-bit significands, normalises the product in one step and cuts it to 24 bits by dropping the low bits. No rounding is done.

Operands enter with a valid strobe and the result leaves two clock cycles later with its own valid strobe and three flags: overflow, underflow and invalid. Operands with a zero exponent field are treated as zero, whatever their fraction. NaN operands and zero times infinity give a single quiet NaN encoding. Results outside the normal range become signed infinity or signed zero.

Top module: `fp32_mul`

## Requirements
- R1: `res_vld` is high exactly two clock cycles after a cycle with `in_vld` high, and low otherwise. While `rst` is high all outputs are zero.
- R2: For every result that is not the invalid NaN, the sign bit (bit 31) equals the XOR of the two operand sign bits.
- R3: For two normal operands (exponent field 1 to 254), the result exponent field is ea + eb - 127, plus one when the 48-bit significand product has bit 47 set. In that case the fraction is product bits 46:24, otherwise bits 45:23.
- R4: The dropped product bits never change the kept fraction. The fraction is cut off, not rounded.
- R5: When the computed exponent field would be 255 or more, the result is infinity (exponent field 255, fraction 0) with the computed sign, and `ovf` is raised.
- R6: When the computed exponent field would be 0 or less, the result is zero with the computed sign (exponent and fraction 0), and `unf` is raised.
- R7: A NaN operand (exponent 255, fraction nonzero), or zero times infinity, gives 0x7FC00000 with `inv` raised.
- R8: Infinity times a nonzero finite value, or infinity times infinity, gives signed infinity with no flag raised.
- R9: An operand with exponent field 0 (zero or denormal) times a finite value gives signed zero with no flag raised.
- R10: At most one of `ovf`, `unf`, `inv` is high in any cycle. All three are low whenever `res_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operands are valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| res_vld | output | 1 | Result is valid this cycle |
| res | output | 32 | Product |
| ovf | output | 1 | Result exceeded the range and was set to infinity |
| unf | output | 1 | Result fell below the range and was set to zero |
| inv | output | 1 | Invalid operation; result is the quiet NaN |

## Verification
The assertions check on every cycle the two-cycle valid latency, the sign rule, the exclusivity of the flags, and that each raised flag comes with its fixed encoding: quiet NaN, infinity or zero. Only the bench scenarios can show that the exponent and fraction values are right. That covers the normalisation choice, truncation in place of rounding, the exact overflow and underflow thresholds at the edge of the range, and the treatment of denormal operands. The bench checks these against a separately written model on hand-picked and random operands.

// File: rtl/fp32_mul.sv
module fp32_mul #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_vld,
  input  logic [EXP_W+FRAC_W:0]     op_a,
  input  logic [EXP_W+FRAC_W:0]     op_b,
  output logic                      res_vld,
  output logic [EXP_W+FRAC_W:0]     res,
  output logic                      ovf,
  output logic                      unf,
  output logic                      inv
);
  localparam int W      = EXP_W + FRAC_W + 1;
  localparam int MANT_W = FRAC_W + 1;
  localparam int PW     = 2 * MANT_W;
  localparam int EMAX   = (1 << EXP_W) - 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [EXP_W+1:0] BIAS_X = BIAS;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  localparam logic [1:0] K_NUM  = 2'd0;
  localparam logic [1:0] K_ZERO = 2'd1;
  localparam logic [1:0] K_INF  = 2'd2;
  localparam logic [1:0] K_NAN  = 2'd3;

  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  assign ea = op_a[W-2 -: EXP_W];
  assign eb = op_b[W-2 -: EXP_W];
  assign fa = op_a[FRAC_W-1:0];
  assign fb = op_b[FRAC_W-1:0];

  logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
  assign a_zero = (ea == '0);
  assign b_zero = (eb == '0);
  assign a_inf  = (ea == '1) && (fa == '0);
  assign b_inf  = (eb == '1) && (fb == '0);
  assign a_nan  = (ea == '1) && (fa != '0);
  assign b_nan  = (eb == '1) && (fb != '0);

  logic [1:0] kind_c;
  always_comb begin
    if (a_nan || b_nan || (a_zero && b_inf) || (a_inf && b_zero)) kind_c = K_NAN;
    else if (a_inf || b_inf)                                       kind_c = K_INF;
    else if (a_zero || b_zero)                                     kind_c = K_ZERO;
    else                                                           kind_c = K_NUM;
  end

  logic              s1_vld, s1_sign;
  logic [1:0]        s1_kind;
  logic [EXP_W:0]    s1_esum;
  logic [PW-1:0]     s1_prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_sign <= 1'b0;
      s1_kind <= K_NUM;
      s1_esum <= '0;
      s1_prod <= '0;
    end else begin
      s1_vld  <= in_vld;
      s1_sign <= op_a[W-1] ^ op_b[W-1];
      s1_kind <= kind_c;
      s1_esum <= {1'b0, ea} + {1'b0, eb};
      s1_prod <= {1'b1, fa} * {1'b1, fb};
    end
  end

  logic                     norm;
  logic [FRAC_W-1:0]        frac_c;
  logic signed [EXP_W+1:0]  e_adj;
  logic                     big_c, small_c;
  assign norm    = s1_prod[PW-1];
  assign frac_c  = norm ? s1_prod[PW-2 -: FRAC_W] : s1_prod[PW-3 -: FRAC_W];
  assign e_adj   = $signed({1'b0, s1_esum}) - BIAS_X + $signed({{(EXP_W+1){1'b0}}, norm});
  assign big_c   = (e_adj >= EMAX);
  assign small_c = (e_adj <= 0);

  logic [W-1:0] res_c;
  logic         ovf_c, unf_c, inv_c;
  always_comb begin
    ovf_c = 1'b0;
    unf_c = 1'b0;
    inv_c = 1'b0;
    case (s1_kind)
      K_NAN:  begin res_c = QNAN; inv_c = 1'b1; end
      K_INF:  res_c = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      K_ZERO: res_c = {s1_sign, {(W-1){1'b0}}};
      default: begin
        if (big_c) begin
          res_c = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          ovf_c = 1'b1;
        end else if (small_c) begin
          res_c = {s1_sign, {(W-1){1'b0}}};
          unf_c = 1'b1;
        end else begin
          res_c = {s1_sign, e_adj[EXP_W-1:0], frac_c};
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res     <= '0;
      ovf     <= 1'b0;
      unf     <= 1'b0;
      inv     <= 1'b0;
    end else begin
      res_vld <= s1_vld;
      res     <= res_c;
      ovf     <= s1_vld & ovf_c;
      unf     <= s1_vld & unf_c;
      inv     <= s1_vld & inv_c;
    end
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> ##1 res_vld);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ##1 !res_vld);
  a_r2_sign: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !inv) |-> (res[W-1] == ($past(op_a[W-1], 2) ^ $past(op_b[W-1], 2))));
  a_r5_ovf_inf: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (res[W-2 -: EXP_W] == '1) && (res[FRAC_W-1:0] == '0));
  a_r6_unf_zero: assert property (@(posedge clk) disable iff (rst)
    unf |-> (res[W-2:0] == '0));
  a_r7_inv_qnan: assert property (@(posedge clk) disable iff (rst)
    inv |-> (res == QNAN));
  a_r10_flags: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf, unf, inv}) && (res_vld || !(ovf || unf || inv)));
endmodule

// File: tb/fp32_mul_tb_top.sv
`timescale 1ns/1ps
module fp32_mul_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        res_vld, ovf, unf, inv;
  logic [31:0] res;

  always #4 clk = ~clk;

  fp32_mul dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .res_vld(res_vld), .res(res), .ovf(ovf), .unf(unf), .inv(inv)
  );

  int checks = 0;
  int fails  = 0;
  logic [34:0] exp_q[$];
  string       tag_q[$];

  // expected {inv, unf, ovf, result}
  function automatic logic [34:0] model(logic [31:0] a, logic [31:0] b);
    logic s;
    int xa, xb, e;
    longint ma, mb, p;
    logic [23:0] m;
    s  = a[31] ^ b[31];
    xa = int'(a[30:23]);
    xb = int'(b[30:23]);
    if ((xa == 255 && a[22:0] != 0) || (xb == 255 && b[22:0] != 0))
      return {3'b100, 32'h7FC00000};
    if ((xa == 255 && xb == 0) || (xa == 0 && xb == 255))
      return {3'b100, 32'h7FC00000};
    if (xa == 255 || xb == 255) return {3'b000, s, 8'hFF, 23'd0};
    if (xa == 0 || xb == 0)     return {3'b000, s, 31'd0};
    ma = longint'({1'b1, a[22:0]});
    mb = longint'({1'b1, b[22:0]});
    p  = ma * mb;
    e  = xa + xb - 127;
    if (p >= (longint'(1) <<< 47)) begin
      m = 24'(p >>> 24);
      e = e + 1;
    end else begin
      m = 24'(p >>> 23);
    end
    if (e > 254) return {3'b001, s, 8'hFF, 23'd0};
    if (e < 1)   return {3'b010, s, 31'd0};
    return {3'b000, s, 8'(e), m[22:0]};
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input string tag);
    @(negedge clk);
    op_a   = a;
    op_b   = b;
    in_vld = 1'b1;
    exp_q.push_back(model(a, b));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (res_vld) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R1 unexpected res_vld actual=1 expected=0");
        end else begin
          logic [34:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          checks++;
          if ({inv, unf, ovf, res} !== e) begin
            fails++;
            $display("FAIL %s actual=%h flags(i,u,o)=%b expected=%h flags=%b",
                     t, res, {inv, unf, ovf}, e[31:0], e[34:32]);
          end
        end
      end else if (ovf || unf || inv) begin
        checks++; fails++;
        $display("FAIL R10 flag without valid actual=%b expected=000", {inv, unf, ovf});
      end
    end
  end

  initial begin
    bit done = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        checks++;
        if ({res_vld, res, ovf, unf, inv} !== '0) begin
          fails++;
          $display("FAIL R1 reset state actual=%h expected=0", {res_vld, res, ovf, unf, inv});
        end
        @(negedge clk); rst = 1'b0;
        idle(2);
        drive(32'h3F800000, 32'h3F800000, "R3 one*one");
        drive(32'h3FC00000, 32'h3FC00000, "R3 normalise 1.5*1.5");
        drive(32'h40000000, 32'h40400000, "R3 two*three");
        drive(32'hC0000000, 32'h40400000, "R2 negative sign");
        drive(32'hC0000000, 32'hC0400000, "R2 both negative");
        drive(32'h3F800001, 32'h3F800001, "R4 truncation low");
        drive(32'h3FFFFFFF, 32'h3FFFFFFF, "R4 truncation high");
        drive(32'h7F000000, 32'h3F800000, "R3 largest exponent");
        drive(32'h00800000, 32'h3F800000, "R3 smallest exponent");
        drive(32'h7F000000, 32'h7F000000, "R5 overflow");
        drive(32'h7F000000, 32'hC0000000, "R5 overflow at boundary negative");
        drive(32'h00800000, 32'h00800000, "R6 underflow");
        drive(32'h80800000, 32'h00800000, "R6 negative underflow");
        drive(32'h00800000, 32'h3F000000, "R6 underflow at boundary");
        drive(32'h7FC00001, 32'h3F800000, "R7 nan operand");
        drive(32'h3F800000, 32'hFF800001, "R7 nan second operand");
        drive(32'h00000000, 32'h7F800000, "R7 zero*inf");
        drive(32'h7F800000, 32'hC0000000, "R8 inf*neg");
        drive(32'hFF800000, 32'hFF800000, "R8 inf*inf");
        drive(32'h80000000, 32'h40A00000, "R9 negzero*five");
        drive(32'h00000001, 32'h3F800000, "R9 denormal as zero");
        idle(1);
        drive(32'h40000000, 32'h40000000, "R1 after gap");
        for (int i = 0; i < 300; i++)
          drive($urandom, $urandom, "R3 random");
        for (int i = 0; i < 200; i++)
          drive({$urandom_range(1, 0), 8'($urandom_range(100, 160)), 23'($urandom)},
                {$urandom_range(1, 0), 8'($urandom_range(100, 160)), 23'($urandom)},
                "R4 random normal");
        idle(6);
        checks++;
        if (exp_q.size() != 0) begin
          fails++;
          $display("FAIL R1 missing results actual=%0d expected=0", exp_q.size());
        end
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL R1 watchdog expired actual=hung expected=done");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule